// File: doc/BRIEF.md
# Protected PWM Group Disable Register

This block holds one control register that can shut off a group of six PWM outputs. The register sits on a simple single-cycle bus with address, write data, write and read strobes, and a 3-bit tag that says which master issued each transfer. When the disable flag is set, every PWM input of the group is replaced by the idle level (logic 0) before it reaches the pin. When the flag is clear, the PWM waveforms pass through without change.

The disable flag cannot be changed by a single stray write. Software first writes the register with the protect bit set, which arms the block. It then writes the register again with the protect bit clear, and the flag takes the value carried in that second write. A write from an ordinary master to any other address between the two steps cancels the pending sequence. Two designated peripheral masters are exempt, and their writes elsewhere leave the sequence armed.

Bits are numbered MSB-first: b0 is data bit 7 and b7 is data bit 0. The bus has no back-pressure. Every strobe completes in the cycle it is presented, and read data comes back combinationally in that same cycle, so the block has no valid/ready handshake.

Top module: `pwm_grp_prot_reg`

## Requirements
- R1: After reset the disable flag is 0, the block is unarmed, all six outputs follow their PWM inputs, and a read of the register returns 0x00.
- R2: A read of the register address returns the disable flag in b7 (data bit 0). All other bits read 0, including the protect bit b6 (data bit 1). A read of any other address returns 0x00.
- R3: A write to the register with b6 = 1 arms the block and leaves the disable flag unchanged.
- R4: If the block is armed, a write to the register with b6 = 0 copies b7 of that write into the disable flag at the same clock edge and leaves the block unarmed.
- R5: If the block is unarmed, a write to the register with b6 = 0 leaves the disable flag unchanged and the block stays unarmed.
- R6: While armed, a write to any other address by a non-exempt master cancels the sequence. Master codes 0 to 4 and 7 are non-exempt.
- R7: While armed, a write to any other address by an exempt master (codes 5 and 6) leaves the block armed.
- R8: While armed, reads of any address and repeated arm writes leave the block armed.
- R9: While the disable flag is 1, all six outputs are 0. While it is 0, each output equals its PWM input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Transfer address |
| bus_wdata | input | 8 | Write data, MSB-first bit numbering |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_mid | input | 3 | Master tag of the current transfer |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| pwm_in | input | 6 | Raw PWM waveforms of the group |
| pwm_out | output | 6 | Gated PWM outputs |

## Verification
The assertions check on every cycle that arm writes and unarmed value writes leave the flag alone, that an armed value write loads the written bit, that a foreign write from a non-exempt master leaves the block unarmed, that the flag changes only through an armed value write, and that the read data and the output gating match the flag. Exempt masters keeping the sequence armed, reads and repeated arm writes not cancelling it, and the long interleavings of masters and addresses can only be shown by the bench. It does this by completing or failing sequences and observing the flag through reads and the gated outputs.

// File: rtl/pwm_grp_prot_pkg.sv
package pwm_grp_prot_pkg;
  localparam int REG_W    = 8;
  // MSB-first numbering: bit bN of the register sits at data index REG_W-1-N
  localparam int B_PROT   = 6;
  localparam int B_DIS    = 7;
  localparam int IDX_PROT = REG_W - 1 - B_PROT;
  localparam int IDX_DIS  = REG_W - 1 - B_DIS;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic self_wr;     // write that targets the register
    logic foreign_wr;  // non-exempt write elsewhere
  } bus_class_t;
endpackage

// File: rtl/ppr_bus_decode.sv
module ppr_bus_decode #(
  parameter int          ADDR_W      = 8,
  parameter int          MID_W       = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  parameter logic [(1<<MID_W)-1:0] EXEMPT_MASK = 8'b0110_0000
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr,
  input  logic [MID_W-1:0]             mid,
  output pwm_grp_prot_pkg::bus_class_t cls
);
  logic addr_hit;
  logic exempt;

  always_comb begin
    addr_hit       = (addr == REG_ADDR);
    exempt         = EXEMPT_MASK[mid];
    cls.self_wr    = wr && addr_hit;
    cls.foreign_wr = wr && !addr_hit && !exempt;
  end
endmodule

// File: rtl/ppr_unlock_seq.sv
module ppr_unlock_seq (
  input  logic                         clk,
  input  logic                         rst_n,
  input  pwm_grp_prot_pkg::bus_class_t cls,
  input  logic                         prot_bit,
  input  logic                         dis_bit,
  output logic                         dis_q,
  output logic                         armed
);
  import pwm_grp_prot_pkg::*;

  seq_state_e state_q, state_d;
  logic       dis_d;

  always_comb begin
    state_d = state_q;
    dis_d   = dis_q;
    if (cls.self_wr) begin
      if (prot_bit) begin
        state_d = SEQ_ARMED;
      end else begin
        if (state_q == SEQ_ARMED) dis_d = dis_bit;
        state_d = SEQ_IDLE;
      end
    end else if (cls.foreign_wr) begin
      state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dis_q   <= dis_d;
    end
  end

  assign armed = (state_q == SEQ_ARMED);
endmodule

// File: rtl/ppr_out_gate.sv
module ppr_out_gate #(
  parameter int   N_OUT      = 6,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic             kill,
  input  logic [N_OUT-1:0] pwm_raw,
  output logic [N_OUT-1:0] pwm_gated
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    assign pwm_gated[g] = kill ? IDLE_LEVEL : pwm_raw[g];
  end
endmodule

// File: rtl/pwm_grp_prot_reg.sv
module pwm_grp_prot_reg #(
  parameter int ADDR_W = 8,
  parameter int MID_W  = 3,
  parameter int N_OUT  = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  parameter logic [(1<<MID_W)-1:0] EXEMPT_MASK = 8'b0110_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [MID_W-1:0]  bus_mid,
  output logic [7:0]        bus_rdata,
  input  logic [N_OUT-1:0]  pwm_in,
  output logic [N_OUT-1:0]  pwm_out
);
  import pwm_grp_prot_pkg::*;

  bus_class_t cls;
  logic       dis_q;
  logic       armed;

  ppr_bus_decode #(
    .ADDR_W(ADDR_W), .MID_W(MID_W),
    .REG_ADDR(REG_ADDR), .EXEMPT_MASK(EXEMPT_MASK)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .mid(bus_mid), .cls(cls)
  );

  ppr_unlock_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cls(cls),
    .prot_bit(bus_wdata[IDX_PROT]), .dis_bit(bus_wdata[IDX_DIS]),
    .dis_q(dis_q), .armed(armed)
  );

  ppr_out_gate #(.N_OUT(N_OUT), .IDLE_LEVEL(1'b0)) u_gate (
    .kill(dis_q), .pwm_raw(pwm_in), .pwm_gated(pwm_out)
  );

  // Read path: only the disable flag is visible; protect bit reads 0
  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (bus_addr == REG_ADDR)) bus_rdata[IDX_DIS] = dis_q;
  end
endmodule

// File: rtl/pwm_grp_prot_chk.sv
module pwm_grp_prot_chk #(
  parameter int ADDR_W = 8,
  parameter int MID_W  = 3,
  parameter int N_OUT  = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  parameter logic [(1<<MID_W)-1:0] EXEMPT_MASK = 8'b0110_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [MID_W-1:0]  bus_mid,
  input logic [7:0]        bus_rdata,
  input logic [N_OUT-1:0]  pwm_in,
  input logic [N_OUT-1:0]  pwm_out,
  input logic              dis_q,
  input logic              armed
);
  logic at_reg, wr_arm, wr_val;
  assign at_reg = (bus_addr == REG_ADDR);
  assign wr_arm = bus_wr && at_reg && bus_wdata[1];
  assign wr_val = bus_wr && at_reg && !bus_wdata[1];

  a_r3_arm_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm |=> ($stable(dis_q) && armed));

  a_r4_armed_value_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && armed) |=> (dis_q == $past(bus_wdata[0]) && !armed));

  a_r5_unarmed_value_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && !armed) |=> ($stable(dis_q) && !armed));

  a_r6_foreign_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !at_reg && !EXEMPT_MASK[bus_mid]) |=> !armed);

  a_r4_flag_only_via_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_val && armed) |=> $stable(dis_q));

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == ((bus_rd && at_reg) ? {7'b0, dis_q} : 8'h00));

  a_r9_gating: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out == (dis_q ? '0 : pwm_in));
endmodule

bind pwm_grp_prot_reg pwm_grp_prot_chk #(
  .ADDR_W(ADDR_W), .MID_W(MID_W), .N_OUT(N_OUT),
  .REG_ADDR(REG_ADDR), .EXEMPT_MASK(EXEMPT_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_mid(bus_mid), .bus_rdata(bus_rdata),
  .pwm_in(pwm_in), .pwm_out(pwm_out), .dis_q(dis_q), .armed(armed)
);

// File: tb/pwm_grp_prot_reg_tb_top.sv
`timescale 1ns/1ps
module pwm_grp_prot_reg_tb_top;
  localparam logic [7:0] REG = 8'h20;
  localparam logic [7:0] OTH = 8'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_mid = '0;
  logic [5:0] pwm_in = '0, pwm_out;

  int n_chk = 0, n_err = 0;
  logic m_dis = 1'b0, m_arm = 1'b0;

  always #4 clk = ~clk;

  pwm_grp_prot_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_mid(bus_mid), .bus_rdata(bus_rdata),
    .pwm_in(pwm_in), .pwm_out(pwm_out)
  );

  function automatic bit is_exempt(input logic [2:0] m);
    return (m == 3'd5) || (m == 3'd6);
  endfunction

  function automatic logic [5:0] exp_out(input logic d, input logic [5:0] p);
    return d ? 6'b0 : p;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // model update from the requirements
  task automatic model_wr(input logic [7:0] a, input logic [7:0] d, input logic [2:0] m);
    if (a == REG) begin
      if (d[1]) m_arm = 1'b1;
      else begin
        if (m_arm) m_dis = d[0];
        m_arm = 1'b0;
      end
    end else if (!is_exempt(m)) m_arm = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [2:0] m);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_mid = m; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d, m);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_flag(input string req);
    logic [7:0] v;
    rd(REG, v);
    check(req, v, {7'b0, m_dis});
    check(req, {2'b0, pwm_out}, {2'b0, exp_out(m_dis, pwm_in)});
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    pwm_in = 6'b101101;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {2'b0, pwm_out}, {2'b0, pwm_in});
    rst_n = 1'b1;
    rd(REG, v); check("R1", v, 8'h00);

    // R5 value write while unarmed ignored, stays unarmed
    wr(REG, 8'h01, 3'd0); chk_flag("R5");
    wr(REG, 8'h01, 3'd0); chk_flag("R5");
    // R3 arm write keeps flag; R4 then loads
    wr(REG, 8'h03, 3'd0); chk_flag("R3");
    wr(REG, 8'h01, 3'd0); chk_flag("R4");
    check("R4", {7'b0, m_dis}, 8'h01);
    // R9 all outputs low while disabled
    pwm_in = 6'b111111; #1;
    check("R9", {2'b0, pwm_out}, 8'h00);
    // R2 protect bit reads 0, other address reads 0
    wr(REG, 8'hFE, 3'd1); rd(REG, v); check("R2", v, 8'h01);
    rd(OTH, v); check("R2", v, 8'h00);
    // state now armed (8'hFE has b6 set): R8 reads/re-arm keep armed
    rd(OTH, v); wr(REG, 8'h02, 3'd2);
    wr(REG, 8'h00, 3'd2); chk_flag("R8");
    check("R8", {7'b0, m_dis}, 8'h00);
    // R6 non-exempt foreign write cancels
    for (int m = 0; m < 8; m++) begin
      wr(REG, 8'h02, 3'd0);
      wr(OTH, 8'hFF, m[2:0]);
      wr(REG, 8'h01, 3'd0);
      chk_flag(is_exempt(m[2:0]) ? "R7" : "R6");
      wr(REG, 8'h02, 3'd0); wr(REG, 8'h00, 3'd0); // restore enable
    end
    // R7 exempt writes keep armed
    wr(REG, 8'h02, 3'd3); wr(8'h10, 8'h00, 3'd5); wr(8'h11, 8'h00, 3'd6);
    wr(REG, 8'h01, 3'd3); chk_flag("R7");
    check("R7", {7'b0, m_dis}, 8'h01);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, d;
      logic [2:0] m;
      a = ($urandom % 3 == 0) ? OTH + 8'($urandom % 4) : REG;
      d = 8'($urandom);
      m = 3'($urandom);
      pwm_in = 6'($urandom);
      if ($urandom % 5 == 0) begin
        rd(a, v);
        check("R2", v, (a == REG) ? {7'b0, m_dis} : 8'h00);
      end else begin
        wr(a, d, m);
        #1 check("R9", {2'b0, pwm_out}, {2'b0, exp_out(m_dis, pwm_in)});
      end
      if (i % 25 == 0) chk_flag("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule